// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Engine

This block sits behind the serial command decoder of a serial non-volatile memory. When a write-to-array command begins, the decoder hands over the start address. The page number (upper address bits) is frozen and an in-page offset starts at the low address bits. Each data byte the decoder assembles is then dropped into a page-sized buffer at the current offset. A valid flag is set for that slot, and the offset advances modulo the page size. A command that keeps sending data past the end of the page therefore wraps around and overwrites earlier slots of the same page.

When chip select returns high, the decoder reports the event together with whether it landed exactly on a byte boundary. The status unit supplies the write-enable latch state and a protection floor: every address at or above the floor is read-only. If the rise is aligned, the latch is set and at least one byte was received, the engine enters a busy period of a fixed number of system clock cycles. During the first page-size cycles of that period it sweeps the buffer in ascending offset order. For every received byte below the floor, it issues one array write per cycle. Bytes never received are not written, so their array contents stay as they were. Commands and bytes that arrive while busy are ignored. At the end of the period a one-cycle pulse tells the status unit to clear its write-enable latch.

Top module: `pageWriteEngine`

## Requirements
- R1: Each received byte goes to address {page, offset}, where page is the start address above the low PAGE_BITS bits and offset starts at the start address's low PAGE_BITS bits. The offset increments by one per byte, and the page never changes within a command.
- R2: After the last slot of the page (offset 2^PAGE_BITS-1) the offset wraps to 0. A later byte for the same offset replaces the earlier one, and only the last value is written.
- R3: A commit starts only if csRise arrives with byteAligned high. An unaligned rise, or a rise with no data byte received, discards the command: no array write, no busy and no clear pulse.
- R4: If wrenLatch is low at the chip-select rise, the command is discarded: no array write, no busy and no clear pulse.
- R5: A commit raises busy in the cycle after the chip-select rise and holds it for exactly max(BUSY_CYCLES, 2^PAGE_BITS) cycles. While busy, cmdStart, byteValid and csRise have no effect: no extra writes occur and the period is not extended.
- R6: wenClear is high for exactly one cycle, the first cycle after busy falls, once per commit.
- R7: No array write is issued to an address greater than or equal to protFloor, which is an (ADDR_W+1)-bit value. A floor of 0 protects all addresses, and a floor of 2^ADDR_W protects none.
- R8: Only received slots are written. The number of array writes equals the number of distinct unprotected offsets received, and all other array locations keep their contents.
- R9: Array writes occur one per cycle at most, only while busy, with strictly ascending offsets within one commit.
- R10: Out of reset, busy, wenClear and arrWrEn are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdStart | input | 1 | One-cycle pulse: a write-to-array command has received its address |
| startAddr | input | ADDR_W | Start address of the command, valid with cmdStart |
| byteValid | input | 1 | One-cycle pulse: a data byte is complete |
| byteData | input | DATA_W | The completed data byte |
| csRise | input | 1 | One-cycle pulse: chip select went inactive |
| byteAligned | input | 1 | The chip-select rise fell exactly after a full byte, valid with csRise |
| wrenLatch | input | 1 | Current write-enable latch state |
| protFloor | input | ADDR_W+1 | Lowest protected address; 2^ADDR_W means no protection |
| busy | output | 1 | Internal write cycle in progress |
| wenClear | output | 1 | One-cycle request to clear the write-enable latch |
| arrWrEn | output | 1 | Array write strobe |
| arrWrAddr | output | ADDR_W | Array write address |
| arrWrData | output | DATA_W | Array write data |

## Verification
The assertions assume that protFloor does not change while busy is high, since the protection check at the top compares write addresses against the live input. They also assume that byteValid and csRise are single-cycle pulses that never coincide with cmdStart. The stimulus changes the floor only between commands, drives every strobe for one cycle, and leaves an idle cycle between bytes. A command is also sent into the middle of a busy period so that the ignore path is exercised while these assumptions still hold.

// File: rtl/pageWritePkg.sv
package pageWritePkg;
  // Strobes from the control FSM to the page datapath.
  typedef struct packed {
    logic load;       // capture start address, clear valid flags
    logic store;      // write incoming byte at current offset
    logic latchProt;  // freeze the protection floor for the commit
    logic sweep;      // present slot sweepIdx on the array port
  } ctrlStrobes_t;
endpackage

// File: rtl/pwControl.sv
module pwControl
  import pageWritePkg::*;
#(
  parameter int PAGE_BITS   = 6,
  parameter int BUSY_CYCLES = 80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdStart,
  input  logic                 byteValid,
  input  logic                 csRise,
  input  logic                 byteAligned,
  input  logic                 wrenLatch,
  input  logic                 anyValid,
  output ctrlStrobes_t         strobes,
  output logic [PAGE_BITS-1:0] sweepIdx,
  output logic                 busy,
  output logic                 wenClear
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int TOTAL      = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;
  localparam int CNT_W      = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_BUSY} state_t;

  state_t            state, nextState;
  logic [CNT_W-1:0]  busyCnt;
  logic              commitOk;
  logic              lastCycle;

  assign commitOk  = byteAligned && wrenLatch && (anyValid || byteValid);
  assign lastCycle = (state == S_BUSY) && (busyCnt == CNT_W'(TOTAL - 1));
  assign busy      = (state == S_BUSY);
  assign sweepIdx  = busyCnt[PAGE_BITS-1:0];

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (cmdStart) begin
          strobes.load = 1'b1;
          nextState    = S_COLLECT;
        end
      end
      S_COLLECT: begin
        strobes.store = byteValid;
        if (csRise) begin
          if (commitOk) begin
            strobes.latchProt = 1'b1;
            nextState         = S_BUSY;
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      S_BUSY: begin
        strobes.sweep = (busyCnt < CNT_W'(PAGE_BYTES));
        if (lastCycle) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busyCnt  <= '0;
      wenClear <= 1'b0;
    end else begin
      state    <= nextState;
      busyCnt  <= (state == S_BUSY) ? busyCnt + 1'b1 : '0;
      wenClear <= lastCycle;
    end
  end

  // The clear request follows the end of a busy period.
  assert_wen_clear_after_busy_R6 : assert property (@(posedge clk) disable iff (!rstN)
    wenClear |-> ($past(busy) && !busy));

  // Busy only begins after an aligned, enabled chip-select rise.
  assert_busy_from_cs_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && byteAligned && wrenLatch));
endmodule

// File: rtl/pwDatapath.sv
module pwDatapath
  import pageWritePkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [PAGE_BITS-1:0] sweepIdx,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [DATA_W-1:0]    byteData,
  input  logic [ADDR_W:0]      protFloor,
  output logic                 anyValid,
  output logic                 arrWrEn,
  output logic [ADDR_W-1:0]    arrWrAddr,
  output logic [DATA_W-1:0]    arrWrData
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int HI_W       = ADDR_W - PAGE_BITS;

  logic [DATA_W-1:0]    bufMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validBits;
  logic [PAGE_BITS-1:0] offset;
  logic [HI_W-1:0]      pageHi;
  logic [ADDR_W:0]      protFloorQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits  <= '0;
      offset     <= '0;
      pageHi     <= '0;
      protFloorQ <= '0;
    end else begin
      if (strobes.load) begin
        pageHi    <= startAddr[ADDR_W-1:PAGE_BITS];
        offset    <= startAddr[PAGE_BITS-1:0];
        validBits <= '0;
      end else if (strobes.store) begin
        validBits[offset] <= 1'b1;
        offset            <= offset + 1'b1;
      end
      if (strobes.latchProt) protFloorQ <= protFloor;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.store && !strobes.load) bufMem[offset] <= byteData;
  end

  assign anyValid  = |validBits;
  assign arrWrAddr = {pageHi, sweepIdx};
  assign arrWrData = bufMem[sweepIdx];
  assign arrWrEn   = strobes.sweep && validBits[sweepIdx] &&
                     ({1'b0, arrWrAddr} < protFloorQ);

  // Page number only moves on a new command.
  assert_page_held_R1 : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(pageHi));

  // Each stored byte advances the in-page offset by one, wrapping.
  assert_offset_step_R1 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.store && !strobes.load) |=> (offset == $past(offset) + 1'b1));
endmodule

// File: rtl/pageWriteEngine.sv
module pageWriteEngine
  import pageWritePkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BITS   = 6,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              csRise,
  input  logic              byteAligned,
  input  logic              wrenLatch,
  input  logic [ADDR_W:0]   protFloor,
  output logic              busy,
  output logic              wenClear,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);
  ctrlStrobes_t         strobes;
  logic [PAGE_BITS-1:0] sweepIdx;
  logic                 anyValid;

  pwControl #(.PAGE_BITS(PAGE_BITS), .BUSY_CYCLES(BUSY_CYCLES)) i_control (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .byteValid(byteValid),
    .csRise(csRise), .byteAligned(byteAligned), .wrenLatch(wrenLatch),
    .anyValid(anyValid), .strobes(strobes), .sweepIdx(sweepIdx),
    .busy(busy), .wenClear(wenClear)
  );

  pwDatapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sweepIdx(sweepIdx),
    .startAddr(startAddr), .byteData(byteData), .protFloor(protFloor),
    .anyValid(anyValid), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr),
    .arrWrData(arrWrData)
  );

  assert_write_in_busy_R5 : assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);

  assert_prot_respected_R7 : assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> ({1'b0, arrWrAddr} < protFloor));

  assert_ascending_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |->
      (arrWrAddr[PAGE_BITS-1:0] > $past(arrWrAddr[PAGE_BITS-1:0])));
endmodule

// File: tb/test_pageWriteEngine.sv
module test_pageWriteEngine;
  localparam int ADDR_W = 8, PAGE_BITS = 6, DATA_W = 8, BUSY_CYCLES = 80;
  localparam int MEM_N = 1 << ADDR_W;
  localparam int TOTAL = 80;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 0, byteValid = 0, csRise = 0, byteAligned = 0, wrenLatch = 0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [DATA_W-1:0] byteData = '0;
  logic [ADDR_W:0]   protFloor = 9'h100;
  logic busy, wenClear, arrWrEn;
  logic [ADDR_W-1:0] arrWrAddr;
  logic [DATA_W-1:0] arrWrData;

  pageWriteEngine #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W),
                    .BUSY_CYCLES(BUSY_CYCLES)) i_pageWriteEngine (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .csRise(csRise),
    .byteAligned(byteAligned), .wrenLatch(wrenLatch), .protFloor(protFloor),
    .busy(busy), .wenClear(wenClear), .arrWrEn(arrWrEn),
    .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] arrMem [MEM_N];
  logic [7:0] expMem [MEM_N];
  int busyCycles = 0, wenPulses = 0, badPulse = 0, writeCount = 0, orderBad = 0;
  logic prevBusy = 0, prevWr = 0;
  logic [PAGE_BITS-1:0] prevIdx = '0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Shadow of the array plus event counters, sampled away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (arrWrEn) begin
        arrMem[arrWrAddr] = arrWrData;
        writeCount++;
        if (prevWr && arrWrAddr[PAGE_BITS-1:0] <= prevIdx) orderBad++;
        prevWr  = 1'b1;
        prevIdx = arrWrAddr[PAGE_BITS-1:0];
        if (!busy) orderBad++;
      end
      if (!busy) prevWr = 1'b0;
      if (busy) busyCycles++;
      if (wenClear) begin
        wenPulses++;
        if (!(prevBusy && !busy)) badPulse++;
      end
      prevBusy = busy;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic logic [7:0] dataOf(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 3);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sendCmd(input logic [7:0] start, input int n, input int seed,
                         input bit aligned, input bit wren, input logic [8:0] fl);
    cmdStart = 1; startAddr = start; step(); cmdStart = 0;
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteData = dataOf(seed, i); step();
      byteValid = 0; step();
    end
    csRise = 1; byteAligned = aligned; wrenLatch = wren; protFloor = fl; step();
    csRise = 0; byteAligned = 0;
  endtask

  task automatic scenario(input string rq, input logic [7:0] start, input int n, input int seed,
                          input bit aligned, input bit wren, input logic [8:0] fl, input bit intrude);
    logic [63:0] seen = '0;
    bit commit = aligned && wren && (n > 0);
    int mism = 0;
    busyCycles = 0; wenPulses = 0; writeCount = 0;
    for (int i = 0; i < n; i++) begin
      logic [5:0] off = 6'(start[5:0] + i);
      logic [7:0] a = {start[7:6], off};
      if (commit && ({1'b0, a} < fl)) begin
        expMem[a] = dataOf(seed, i);
        seen[off] = 1'b1;
      end
    end
    sendCmd(start, n, seed, aligned, wren, fl);
    if (intrude) begin
      repeat (5) step();
      sendCmd(8'h80, 6, seed + 1, 1'b1, 1'b1, fl);  // must be ignored while busy
    end
    repeat (TOTAL + 6) step();
    wrenLatch = 0;
    for (int a = 0; a < MEM_N; a++) if (arrMem[a] !== expMem[a]) mism++;
    chk(mism == 0, rq, "array mismatches", mism, 0);
    chk(busyCycles == (commit ? TOTAL : 0), rq, "busy cycles", busyCycles, commit ? TOTAL : 0);
    chk(wenPulses == (commit ? 1 : 0), rq, "wenClear pulses", wenPulses, commit ? 1 : 0);
    chk(writeCount == $countones(seen), rq, "array writes", writeCount, $countones(seen));
  endtask

  initial begin
    for (int a = 0; a < MEM_N; a++) begin
      arrMem[a] = 8'(a) ^ 8'h5A;
      expMem[a] = 8'(a) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0, "R10", "busy in reset", int'(busy), 0);
    chk(wenClear == 0, "R10", "wenClear in reset", int'(wenClear), 0);
    chk(arrWrEn == 0, "R10", "arrWrEn in reset", int'(arrWrEn), 0);
    rstN = 1;
    step();
    scenario("R1", 8'h45, 5, 1, 1, 1, 9'h100, 0);   // mid-page, partial (R8 too)
    scenario("R1", 8'h3E, 4, 2, 1, 1, 9'h100, 0);   // offset wraps, page 0 kept
    scenario("R2", 8'hC8, 70, 3, 1, 1, 9'h100, 0);  // more than a page: overwrite
    scenario("R3", 8'h10, 3, 4, 0, 1, 9'h100, 0);   // unaligned rise discards
    scenario("R3", 8'h20, 0, 5, 1, 1, 9'h100, 0);   // no data bytes: no cycle
    scenario("R4", 8'h30, 3, 6, 1, 0, 9'h100, 0);   // latch clear discards
    scenario("R7", 8'h50, 20, 7, 1, 1, 9'h05A, 0);  // floor inside the run
    scenario("R7", 8'h04, 4, 8, 1, 1, 9'h000, 0);   // everything protected
    scenario("R5", 8'h70, 7, 9, 1, 1, 9'h100, 1);   // command during busy ignored
    scenario("R8", 8'h00, 64, 10, 1, 1, 9'h100, 0); // full page
    chk(orderBad == 0, "R9", "out-of-order or idle writes", orderBad, 0);
    chk(badPulse == 0, "R6", "misplaced wenClear", badPulse, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule